// File: doc/BRIEF.md
# Link Data Rate Negotiation Tracker

This block follows link training and decides when a serial link may step up from 2.5 Gbps to 5.0 Gbps. It watches the training state code driven by the link training state machine. It also watches a strobe that marks each received training set, together with that set's data-rate identifier field. From these it keeps a record of the speeds the far end says it supports. Every lane shares one rate, so the block holds a single operating-rate flag for the whole link.

A full train that starts from Detect always runs at 2.5 Gbps first. Support for 2.5 Gbps is mandatory and support for 5.0 Gbps is optional. Once the link sits in L0, and both the local speed mask and the recorded partner mask include 5.0 Gbps, the block sends the state machine one request pulse. The state machine then retrains through Recovery. The rate is committed on the next return to L0, so the data-link layer never goes down for a speed change. The training-set strobe is a plain per-cycle event with no back-pressure: the block accepts a strobe in every cycle and never stalls the decoder that feeds it.

Top module: `lrate_tracker`

## Requirements
- R1: While reset is asserted, `partner_speeds` is 2'b01, `oper_rate` is 0 (2.5 Gbps) and `upgrade_req` is 0.
- R2: In the cycle after `ts_valid` is high with `ltssm_state` equal to the configuration-complete code (default 5'h0D) and identifier bit 0 set, `partner_speeds` equals the identifier. Bit 0 means 2.5 Gbps and bit 1 means 5.0 Gbps.
- R3: An identifier captured in the recovery receiver-config state (default code 5'h12) is recorded in the same way, and the newest capture replaces any older value.
- R4: A strobe that arrives in any other state leaves `partner_speeds` unchanged.
- R5: An identifier with bit 0 clear is treated as malformed and leaves `partner_speeds` unchanged.
- R6: When `ltssm_state` is L0 (default 5'h10), `oper_rate` is 0 and bit 1 is set in both `local_speeds` and `partner_speeds`, `upgrade_req` goes high in the next cycle for exactly one cycle. It goes high at most once per stay in L0.
- R7: `upgrade_req` stays low outside L0, and also while either mask lacks bit 1.
- R8: After a request, `oper_rate` becomes 1 on the next entry into L0, but only if both masks still include bit 1 at that entry. Otherwise it stays 0 and the request is dropped.
- R9: While `oper_rate` is 1, an entry into L0 at which either mask lacks bit 1 returns `oper_rate` to 0.
- R10: `detect_entry` resets `partner_speeds` to 2'b01 and `oper_rate` to 0 and cancels any request. It takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ltssm_state | input | STATE_W | Current training state code |
| ts_valid | input | 1 | A training set was received this cycle |
| ts_rate_id | input | 2 | Data-rate identifier of the received set |
| local_speeds | input | 2 | Speeds supported by this end |
| detect_entry | input | 1 | Pulse: the state machine entered Detect |
| partner_speeds | output | 2 | Recorded speeds of the far end |
| oper_rate | output | 1 | Operating rate: 0 = 2.5 Gbps, 1 = 5.0 Gbps |
| upgrade_req | output | 1 | One-cycle request to retrain at 5.0 Gbps |

## Verification
The bench builds the block with its default parameters: a 5-bit state code and the codes 5'h0D, 5'h12 and 5'h10 for the two capture states and L0. These defaults let the bench drive every path by plain code values: captures in both substates, strobes in other states, malformed identifiers, and repeated Recovery/L0 round trips. Those round trips show a rate rising, falling back, and a request lost when the partner withdraws 5.0 Gbps. A Detect pulse that coincides with a capture shows the reset taking priority.

// File: rtl/lrate_pkg.sv
`timescale 1ns/1ps
package lrate_pkg;
  localparam int SPD_W  = 2;
  localparam int SPD_LO = 0;
  localparam int SPD_HI = 1;
  localparam logic [SPD_W-1:0] SPD_BASE = 2'b01;

  typedef enum logic {
    RATE_2G5 = 1'b0,
    RATE_5G0 = 1'b1
  } rate_e;
endpackage

// File: rtl/lrate_adv_capture.sv
`timescale 1ns/1ps
module lrate_adv_capture
  import lrate_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter logic [STATE_W-1:0] ST_CFG_DONE = 5'h0D,
  parameter logic [STATE_W-1:0] ST_RCV_CFG  = 5'h12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               ts_valid,
  input  logic [SPD_W-1:0]   ts_rate_id,
  input  logic               detect_entry,
  output logic [SPD_W-1:0]   partner_speeds
);
  logic in_window;
  logic well_formed;
  logic take;
  logic [SPD_W-1:0] rec_q;

  assign in_window   = (ltssm_state == ST_CFG_DONE) || (ltssm_state == ST_RCV_CFG);
  assign well_formed = ts_rate_id[SPD_LO];
  assign take        = ts_valid && in_window && well_formed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_q <= SPD_BASE;
    else if (detect_entry) rec_q <= SPD_BASE;
    else if (take)         rec_q <= ts_rate_id;
  end

  assign partner_speeds = rec_q;
endmodule

// File: rtl/lrate_ctrl.sv
`timescale 1ns/1ps
module lrate_ctrl
  import lrate_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter logic [STATE_W-1:0] ST_L0 = 5'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic [SPD_W-1:0]   local_speeds,
  input  logic [SPD_W-1:0]   partner_speeds,
  input  logic               detect_entry,
  output logic               oper_rate,
  output logic               upgrade_req
);
  rate_e rate_q;
  logic  was_l0_q, fired_q, pending_q, req_q;
  logic  in_l0, l0_entry, both_hi, go;

  assign in_l0    = (ltssm_state == ST_L0);
  assign l0_entry = in_l0 && !was_l0_q;
  assign both_hi  = local_speeds[SPD_HI] && partner_speeds[SPD_HI];
  assign go       = in_l0 && !fired_q && !pending_q && (rate_q == RATE_2G5) && both_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_l0_q  <= 1'b0;
      fired_q   <= 1'b0;
      pending_q <= 1'b0;
      req_q     <= 1'b0;
      rate_q    <= RATE_2G5;
    end else if (detect_entry) begin
      was_l0_q  <= in_l0;
      fired_q   <= 1'b0;
      pending_q <= 1'b0;
      req_q     <= 1'b0;
      rate_q    <= RATE_2G5;
    end else begin
      was_l0_q <= in_l0;
      req_q    <= go;
      fired_q  <= in_l0 && (fired_q || go);
      if (go)            pending_q <= 1'b1;
      else if (l0_entry) pending_q <= 1'b0;
      if (l0_entry) begin
        if (pending_q && both_hi)                    rate_q <= RATE_5G0;
        else if ((rate_q == RATE_5G0) && !both_hi)   rate_q <= RATE_2G5;
      end
    end
  end

  assign oper_rate   = rate_q;
  assign upgrade_req = req_q;
endmodule

// File: rtl/lrate_tracker.sv
`timescale 1ns/1ps
module lrate_tracker
  import lrate_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter logic [STATE_W-1:0] ST_CFG_DONE = 5'h0D,
  parameter logic [STATE_W-1:0] ST_RCV_CFG  = 5'h12,
  parameter logic [STATE_W-1:0] ST_L0       = 5'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               ts_valid,
  input  logic [1:0]         ts_rate_id,
  input  logic [1:0]         local_speeds,
  input  logic               detect_entry,
  output logic [1:0]         partner_speeds,
  output logic               oper_rate,
  output logic               upgrade_req
);
  logic [SPD_W-1:0] partner_w;

  lrate_adv_capture #(
    .STATE_W(STATE_W), .ST_CFG_DONE(ST_CFG_DONE), .ST_RCV_CFG(ST_RCV_CFG)
  ) cap_i (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
    .ts_valid(ts_valid), .ts_rate_id(ts_rate_id),
    .detect_entry(detect_entry), .partner_speeds(partner_w)
  );

  lrate_ctrl #(
    .STATE_W(STATE_W), .ST_L0(ST_L0)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
    .local_speeds(local_speeds), .partner_speeds(partner_w),
    .detect_entry(detect_entry), .oper_rate(oper_rate),
    .upgrade_req(upgrade_req)
  );

  assign partner_speeds = partner_w;
endmodule

// File: rtl/lrate_tracker_chk.sv
`timescale 1ns/1ps
module lrate_tracker_chk #(
  parameter int STATE_W = 5,
  parameter logic [STATE_W-1:0] ST_CFG_DONE = 5'h0D,
  parameter logic [STATE_W-1:0] ST_RCV_CFG  = 5'h12,
  parameter logic [STATE_W-1:0] ST_L0       = 5'h10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] ltssm_state,
  input logic               ts_valid,
  input logic [1:0]         ts_rate_id,
  input logic [1:0]         local_speeds,
  input logic               detect_entry,
  input logic [1:0]         partner_speeds,
  input logic               oper_rate,
  input logic               upgrade_req
);
  p_base_speed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    partner_speeds[0]);

  p_hold_outside_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!detect_entry && !(ts_valid && (ltssm_state == ST_CFG_DONE || ltssm_state == ST_RCV_CFG)))
    |=> $stable(partner_speeds));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upgrade_req |=> !upgrade_req);

  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upgrade_req |-> ($past(ltssm_state) == ST_L0) && $past(local_speeds[1])
                    && $past(partner_speeds[1]) && !$past(oper_rate));

  p_rise_at_l0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oper_rate) |-> ($past(ltssm_state) == ST_L0) && !$past(detect_entry));

  p_detect_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    detect_entry |=> (partner_speeds == 2'b01) && !oper_rate && !upgrade_req);
endmodule

bind lrate_tracker lrate_tracker_chk #(
  .STATE_W(STATE_W), .ST_CFG_DONE(ST_CFG_DONE), .ST_RCV_CFG(ST_RCV_CFG), .ST_L0(ST_L0)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state), .ts_valid(ts_valid),
  .ts_rate_id(ts_rate_id), .local_speeds(local_speeds), .detect_entry(detect_entry),
  .partner_speeds(partner_speeds), .oper_rate(oper_rate), .upgrade_req(upgrade_req)
);

// File: tb/lrate_tracker_tb_top.sv
`timescale 1ns/1ps
module lrate_tracker_tb_top;
  localparam logic [4:0] S_IDLE = 5'h01;
  localparam logic [4:0] S_CC   = 5'h0D;
  localparam logic [4:0] S_RC   = 5'h12;
  localparam logic [4:0] S_L0   = 5'h10;

  typedef struct {
    logic [1:0] partner;
    logic       rate;
    logic       req;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ltssm_state = S_IDLE;
  logic       ts_valid = 1'b0;
  logic [1:0] ts_rate_id = 2'b00;
  logic [1:0] local_speeds = 2'b11;
  logic       detect_entry = 1'b0;
  logic [1:0] partner_speeds;
  logic       oper_rate;
  logic       upgrade_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  lrate_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state), .ts_valid(ts_valid),
    .ts_rate_id(ts_rate_id), .local_speeds(local_speeds), .detect_entry(detect_entry),
    .partner_speeds(partner_speeds), .oper_rate(oper_rate), .upgrade_req(upgrade_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the outputs expected after the next edge
  task automatic cyc(logic [4:0] st, logic v, logic [1:0] id, logic [1:0] loc, logic det,
                     logic [1:0] ep, logic er, logic eq, string tag);
    exp_t e;
    @(negedge clk);
    ltssm_state  = st;
    ts_valid     = v;
    ts_rate_id   = id;
    local_speeds = loc;
    detect_entry = det;
    e.partner = ep; e.rate = er; e.req = eq; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "partner_speeds", int'(partner_speeds), int'(e.partner));
      chk(e.tag, "oper_rate", int'(oper_rate), int'(e.rate));
      chk(e.tag, "upgrade_req", int'(upgrade_req), int'(e.req));
    end
  end

  initial begin
    #4000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1", "partner_speeds", int'(partner_speeds), 1);
    chk("R1", "oper_rate", int'(oper_rate), 0);
    chk("R1", "upgrade_req", int'(upgrade_req), 0);
    rst_n = 1'b1;
    cyc(S_IDLE, 0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R1");
    // R4: strobes outside the capture states
    cyc(S_IDLE, 1, 2'b11, 2'b11, 0, 2'b01, 0, 0, "R4");
    cyc(S_L0,   1, 2'b11, 2'b11, 0, 2'b01, 0, 0, "R4");
    // R5: malformed identifier
    cyc(S_CC,   1, 2'b10, 2'b11, 0, 2'b01, 0, 0, "R5");
    // R2: capture in configuration-complete
    cyc(S_CC,   1, 2'b11, 2'b11, 0, 2'b11, 0, 0, "R2");
    // R3: capture in recovery receiver-config, newest wins
    cyc(S_RC,   1, 2'b01, 2'b11, 0, 2'b01, 0, 0, "R3");
    cyc(S_RC,   1, 2'b11, 2'b11, 0, 2'b11, 0, 0, "R3");
    // R7: local mask lacks 5.0, then outside L0
    cyc(S_L0,   0, 2'b00, 2'b01, 0, 2'b11, 0, 0, "R7");
    cyc(S_L0,   0, 2'b00, 2'b01, 0, 2'b11, 0, 0, "R7");
    cyc(S_IDLE, 0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R7");
    // R6: single pulse per L0 stay
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 1, "R6");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R6");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R6");
    // R8: commit on the next L0 entry
    cyc(S_RC,   1, 2'b11, 2'b11, 0, 2'b11, 0, 0, "R8");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 1, 0, "R8");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 1, 0, "R8");
    // R9: partner withdraws 5.0, rate falls back on L0 entry
    cyc(S_RC,   1, 2'b01, 2'b11, 0, 2'b01, 1, 0, "R9");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R9");
    // R8: request dropped when partner withdraws before re-entry
    cyc(S_RC,   1, 2'b11, 2'b11, 0, 2'b11, 0, 0, "R8");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 1, "R8");
    cyc(S_RC,   1, 2'b01, 2'b11, 0, 2'b01, 0, 0, "R8");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R8");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R8");
    // R9: local mask drop at L0 entry
    cyc(S_RC,   1, 2'b11, 2'b11, 0, 2'b11, 0, 0, "R9");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 1, "R9");
    cyc(S_RC,   0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R9");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 1, 0, "R9");
    cyc(S_RC,   0, 2'b00, 2'b01, 0, 2'b11, 1, 0, "R9");
    cyc(S_L0,   0, 2'b00, 2'b01, 0, 2'b11, 0, 0, "R9");
    // R10: back to 5.0, then Detect pulse together with a capture
    cyc(S_RC,   0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R10");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 0, 1, "R10");
    cyc(S_RC,   0, 2'b00, 2'b11, 0, 2'b11, 0, 0, "R10");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b11, 1, 0, "R10");
    cyc(S_CC,   1, 2'b11, 2'b11, 1, 2'b01, 0, 0, "R10");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R10");
    cyc(S_L0,   0, 2'b00, 2'b11, 0, 2'b01, 0, 0, "R10");
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule